// File: doc/BRIEF.md
# Speech Wake Supervisor

This block sits between an always-running voice activity detector and a speech recognizer that can be power-gated. It accepts every audio sample and every per-frame speech decision regardless of what the recognizer is doing. While the input is judged to be non-speech, it keeps the recognizer in reset with its power gate off. Decisions are not acted on until the detector reports that its classifier parameters have finished loading.

A speech frame wakes the recognizer. Power is enabled first, and reset is released a fixed number of settle cycles later. All the while, a circular sample store keeps the most recent audio. At wake-up, a read position is placed a pre-roll distance behind the newest sample, so the speech that caused the wake-up is not lost. The recognizer then pulls samples in order with a request strobe, and each request is answered by a valid strobe one cycle later. When speech stops, the recognizer stays awake for a hangover of consecutive non-speech frames. It is then reset and power-gated again, and its unread samples are discarded.

The states are LOAD, IDLE, POWER_UP, ACTIVE and HANGOVER, held in a one-hot register. The transitions are:
- LOAD to IDLE: load done.
- IDLE to POWER_UP: speech frame, which is the wake event.
- POWER_UP to ACTIVE: settle count reached.
- ACTIVE to HANGOVER: non-speech frame.
- HANGOVER to ACTIVE: speech frame.
- HANGOVER to IDLE: the last hangover frame, which is the sleep event. When the hangover length is 1, ACTIVE goes to IDLE directly.

Top module: `speech_wake_sup`

## Requirements
- R1: After reset the block is in LOAD: `rec_pwr_en`=0, `rec_rst_n`=0, `rd_valid`=0, `ovf_flag`=0.
- R2: In LOAD, frame decisions have no effect and `rec_pwr_en` stays 0. With `load_done`=1 the block enters IDLE at the next clock edge.
- R3: In IDLE, a frame with `frame_valid`=1 and `frame_speech`=1 raises `rec_pwr_en` at the next edge, while `rec_rst_n` stays 0.
- R4: `rec_rst_n` rises exactly SETTLE_CYC clock edges after `rec_pwr_en` rises. Frame decisions during POWER_UP are ignored.
- R5: A sample with `smp_valid`=1 is stored in every state, including LOAD and IDLE. The store keeps the last DEPTH samples.
- R6: At the wake edge the read position is set min(PREROLL, samples stored since reset) behind the write position. The first read after wake-up therefore returns the sample written PREROLL writes before the wake.
- R7: When `rec_rst_n`=1 and unread samples exist, an `rd_req` sampled at an edge gives `rd_valid`=1 with the next sample in write order after that edge. An `rd_req` made with nothing unread, or while `rec_rst_n`=0, produces no `rd_valid`.
- R8: A write when DEPTH samples are unread drops the oldest unread sample and sets `ovf_flag`, which stays set until it clears at the next wake edge.
- R9: A non-speech frame in ACTIVE starts the hangover, and a speech frame in HANGOVER returns to ACTIVE and restarts the count. On the HANG_FRAMES-th consecutive non-speech frame, `rec_pwr_en` and `rec_rst_n` both fall at that edge.
- R10: Entering IDLE discards all unread samples. After the next wake, only the pre-roll is readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_done | input | 1 | Detector parameters loaded; decisions are valid |
| smp_valid | input | 1 | Audio sample strobe |
| smp_data | input | SAMPLE_W | Audio sample |
| frame_valid | input | 1 | Frame decision strobe |
| frame_speech | input | 1 | 1 = frame judged speech |
| rec_pwr_en | output | 1 | Recognizer power gate enable |
| rec_rst_n | output | 1 | Recognizer active-low reset |
| rd_req | input | 1 | Recognizer sample request |
| rd_valid | output | 1 | Returned sample valid |
| rd_data | output | SAMPLE_W | Returned sample |
| ovf_flag | output | 1 | Sticky loss-of-samples flag |

## Verification
A wrong state code shows at the power and reset pins within one edge of the frame that should have moved it, because both outputs decode straight from the state register. A wrong settle or hangover count shifts the edge where `rec_rst_n` rises or where both outputs fall, so the bench checks the cycle of that edge, not just its level. A wrong read position or unread count shows as the wrong sample value on the first read after wake-up, a missing or extra `rd_valid` at the empty boundary, or an `ovf_flag` that rises one sample too early or too late.

// File: rtl/sws_pkg.sv
package sws_pkg;

    typedef enum logic [4:0] {
        ST_LOAD   = 5'b00001,
        ST_IDLE   = 5'b00010,
        ST_PWRUP  = 5'b00100,
        ST_ACTIVE = 5'b01000,
        ST_HANG   = 5'b10000
    } sup_state_e;

endpackage

// File: rtl/sws_fsm.sv
module sws_fsm
    import sws_pkg::*;
#(
    parameter int SETTLE_CYC  = 16,
    parameter int HANG_FRAMES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_done,
    input  logic frame_valid,
    input  logic frame_speech,
    output logic rec_pwr_en,
    output logic rec_rst_n,
    output logic wake_o,
    output logic sleep_o
);

    localparam int SET_W  = $clog2(SETTLE_CYC + 1);
    localparam int HANG_W = $clog2(HANG_FRAMES + 1);
    localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETTLE_CYC - 1);
    localparam logic [HANG_W-1:0] HANG_LAST = HANG_W'(HANG_FRAMES - 1);

    sup_state_e        state_q, state_d;
    logic [SET_W-1:0]  settle_q;
    logic [HANG_W-1:0] hang_q;

    logic sp_frame, ns_frame;
    assign sp_frame = frame_valid &&  frame_speech;
    assign ns_frame = frame_valid && !frame_speech;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOAD:   if (load_done) state_d = ST_IDLE;
            ST_IDLE:   if (sp_frame)  state_d = ST_PWRUP;
            ST_PWRUP:  if (settle_q == SET_LAST) state_d = ST_ACTIVE;
            ST_ACTIVE: if (ns_frame) state_d = (HANG_FRAMES <= 1) ? ST_IDLE : ST_HANG;
            ST_HANG: begin
                if (sp_frame)
                    state_d = ST_ACTIVE;
                else if (ns_frame && hang_q == HANG_LAST)
                    state_d = ST_IDLE;
            end
            default:   state_d = ST_LOAD;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // settle and hangover counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            settle_q <= '0;
            hang_q   <= '0;
        end else begin
            if (state_q == ST_PWRUP) settle_q <= settle_q + SET_W'(1);
            else                     settle_q <= '0;

            if (state_q == ST_ACTIVE && ns_frame)      hang_q <= HANG_W'(1);
            else if (state_q == ST_HANG && ns_frame)   hang_q <= hang_q + HANG_W'(1);
            else if (state_q == ST_HANG && sp_frame)   hang_q <= '0;
        end
    end

    // outputs
    always_comb begin
        rec_pwr_en = 1'b0;
        rec_rst_n  = 1'b0;
        unique case (state_q)
            ST_LOAD, ST_IDLE: begin
                rec_pwr_en = 1'b0;
                rec_rst_n  = 1'b0;
            end
            ST_PWRUP: begin
                rec_pwr_en = 1'b1;
                rec_rst_n  = 1'b0;
            end
            ST_ACTIVE, ST_HANG: begin
                rec_pwr_en = 1'b1;
                rec_rst_n  = 1'b1;
            end
            default: begin
                rec_pwr_en = 1'b0;
                rec_rst_n  = 1'b0;
            end
        endcase
    end

    assign wake_o  = (state_q == ST_IDLE) && sp_frame;
    assign sleep_o = (state_q == ST_ACTIVE || state_q == ST_HANG) && (state_d == ST_IDLE);

    // R9
    onehot_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state_q) == 1);

    // R2
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD) |=> (state_q == ST_LOAD || state_q == ST_IDLE));

    // R4
    pwr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rec_pwr_en) |-> !rec_rst_n);

    // R3
    wake_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> (rec_pwr_en && !rec_rst_n));

endmodule

// File: rtl/sws_ring.sv
module sws_ring #(
    parameter int SAMPLE_W = 16,
    parameter int DEPTH    = 1024,
    parameter int PREROLL  = 256
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                wake_i,
    input  logic                sleep_i,
    input  logic                rd_en_i,
    input  logic                rd_req_i,
    output logic                rd_valid_o,
    output logic [SAMPLE_W-1:0] rd_data_o,
    output logic                ovf_o
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] PRE_C   = CW'(PREROLL);

    logic [SAMPLE_W-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] avail, hist;
    logic          live;

    logic [CW-1:0] pre_take;
    logic          pop, full;

    assign pre_take = (hist < PRE_C) ? hist : PRE_C;
    assign full     = (avail == DEPTH_C);
    assign pop      = live && rd_en_i && rd_req_i && (avail != '0) && !sleep_i;

    // sample store, no reset
    always_ff @(posedge clk) begin
        if (smp_valid) mem[wr_ptr] <= smp_data;
        if (pop)       rd_data_o   <= mem[rd_ptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            avail      <= '0;
            hist       <= '0;
            live       <= 1'b0;
            ovf_o      <= 1'b0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= pop;
            if (smp_valid) begin
                wr_ptr <= wr_ptr + AW'(1);
                if (hist != DEPTH_C) hist <= hist + CW'(1);
            end
            if (wake_i) begin
                rd_ptr <= wr_ptr - pre_take[AW-1:0];
                avail  <= pre_take + CW'(smp_valid);
                ovf_o  <= 1'b0;
                live   <= 1'b1;
            end else if (sleep_i) begin
                avail  <= '0;
                live   <= 1'b0;
            end else if (live) begin
                unique case ({smp_valid, pop})
                    2'b11: rd_ptr <= rd_ptr + AW'(1);
                    2'b10: begin
                        if (full) begin
                            rd_ptr <= rd_ptr + AW'(1);
                            ovf_o  <= 1'b1;
                        end else begin
                            avail  <= avail + CW'(1);
                        end
                    end
                    2'b01: begin
                        rd_ptr <= rd_ptr + AW'(1);
                        avail  <= avail - CW'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

    // R8
    avail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= DEPTH_C);

    // R7
    rd_valid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o |-> $past(rd_req_i && rd_en_i));

    // R8
    ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_i |=> !ovf_o);

    // R10
    sleep_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> !rd_valid_o);

endmodule

// File: rtl/speech_wake_sup.sv
module speech_wake_sup #(
    parameter int SAMPLE_W    = 16,
    parameter int DEPTH       = 1024,
    parameter int PREROLL     = 256,
    parameter int SETTLE_CYC  = 16,
    parameter int HANG_FRAMES = 30
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_done,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic                frame_valid,
    input  logic                frame_speech,
    output logic                rec_pwr_en,
    output logic                rec_rst_n,
    input  logic                rd_req,
    output logic                rd_valid,
    output logic [SAMPLE_W-1:0] rd_data,
    output logic                ovf_flag
);

    logic wake, sleep;

    sws_fsm #(
        .SETTLE_CYC (SETTLE_CYC),
        .HANG_FRAMES(HANG_FRAMES)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_done   (load_done),
        .frame_valid (frame_valid),
        .frame_speech(frame_speech),
        .rec_pwr_en  (rec_pwr_en),
        .rec_rst_n   (rec_rst_n),
        .wake_o      (wake),
        .sleep_o     (sleep)
    );

    sws_ring #(
        .SAMPLE_W(SAMPLE_W),
        .DEPTH   (DEPTH),
        .PREROLL (PREROLL)
    ) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .wake_i    (wake),
        .sleep_i   (sleep),
        .rd_en_i   (rec_rst_n),
        .rd_req_i  (rd_req),
        .rd_valid_o(rd_valid),
        .rd_data_o (rd_data),
        .ovf_o     (ovf_flag)
    );

    // R7
    no_read_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rec_rst_n));

endmodule

// File: tb/test_speech_wake_sup.sv
module test_speech_wake_sup;

    localparam int SW  = 16;
    localparam int DEP = 32;
    localparam int PRE = 8;
    localparam int SET = 4;
    localparam int HNG = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_done = 1'b0;
    logic smp_valid = 1'b0;
    logic [SW-1:0] smp_data = '0;
    logic frame_valid = 1'b0;
    logic frame_speech = 1'b0;
    logic rd_req = 1'b0;
    logic rec_pwr_en, rec_rst_n, rd_valid, ovf_flag;
    logic [SW-1:0] rd_data;

    int n_chk = 0;
    int n_fail = 0;
    int nxt = 100;

    // bit2 speech, bit1 expected power, bit0 expected reset release
    localparam logic [2:0] HANG_VEC [6] = '{3'b011, 3'b011, 3'b111, 3'b011, 3'b011, 3'b000};

    always #10 clk = ~clk;

    speech_wake_sup #(
        .SAMPLE_W(SW), .DEPTH(DEP), .PREROLL(PRE),
        .SETTLE_CYC(SET), .HANG_FRAMES(HNG)
    ) i_speech_wake_sup (
        .clk(clk), .rst_n(rst_n), .load_done(load_done),
        .smp_valid(smp_valid), .smp_data(smp_data),
        .frame_valid(frame_valid), .frame_speech(frame_speech),
        .rec_pwr_en(rec_pwr_en), .rec_rst_n(rec_rst_n),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .ovf_flag(ovf_flag)
    );

    task automatic chk_eq(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push();
        smp_valid = 1'b1;
        smp_data  = SW'(nxt);
        @(negedge clk);
        smp_valid = 1'b0;
        nxt++;
    endtask

    task automatic frame(bit sp);
        frame_valid  = 1'b1;
        frame_speech = sp;
        @(negedge clk);
        frame_valid  = 1'b0;
    endtask

    task automatic read(string tag, bit exp_v, int exp_d);
        rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        chk_eq({tag, " valid"}, int'(rd_valid), int'(exp_v));
        if (exp_v) chk_eq({tag, " data"}, int'(rd_data), exp_d);
    endtask

    task automatic settle(string tag);
        for (int i = 1; i < SET; i++) begin
            @(negedge clk);
            chk_eq({tag, " reset held"}, int'(rec_rst_n), 0);
        end
        @(negedge clk);
        chk_eq({tag, " reset released"}, int'(rec_rst_n), 1);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk_eq("R1 pwr", int'(rec_pwr_en), 0);
        chk_eq("R1 rst", int'(rec_rst_n), 0);
        chk_eq("R1 valid", int'(rd_valid), 0);
        chk_eq("R1 ovf", int'(ovf_flag), 0);

        // R5: samples accepted in LOAD; R2: decisions ignored in LOAD
        for (int i = 0; i < 5; i++) push();
        frame(1'b1);
        @(negedge clk);
        chk_eq("R2 load ignores speech", int'(rec_pwr_en), 0);
        load_done = 1'b1;
        @(negedge clk);
        chk_eq("R2 idle pwr", int'(rec_pwr_en), 0);

        // R5: fill past depth in IDLE
        while (nxt < 140) push();

        // R3 wake
        frame(1'b1);
        chk_eq("R3 pwr up", int'(rec_pwr_en), 1);
        chk_eq("R3 rst held", int'(rec_rst_n), 0);

        // R4 settle with an ignored non-speech frame and an early request (R7)
        frame_valid = 1'b1; frame_speech = 1'b0; rd_req = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0; rd_req = 1'b0;
        chk_eq("R7 request during reset", int'(rd_valid), 0);
        chk_eq("R4 reset held", int'(rec_rst_n), 0);
        for (int i = 2; i < SET; i++) begin
            @(negedge clk);
            chk_eq("R4 reset held", int'(rec_rst_n), 0);
        end
        @(negedge clk);
        chk_eq("R4 reset released", int'(rec_rst_n), 1);

        // R6 R7 pre-roll in order
        for (int k = 0; k < PRE; k++) read("R6 preroll", 1'b1, 132 + k);
        read("R7 empty", 1'b0, 0);
        push();
        read("R7 new sample", 1'b1, 140);

        // R8 overflow boundary
        for (int k = 0; k < DEP; k++) push();
        chk_eq("R8 full no ovf", int'(ovf_flag), 0);
        push();
        chk_eq("R8 ovf set", int'(ovf_flag), 1);
        read("R8 oldest dropped", 1'b1, 142);

        // R9 hangover table
        for (int i = 0; i < 6; i++) begin
            frame(HANG_VEC[i][2]);
            chk_eq("R9 pwr", int'(rec_pwr_en), int'(HANG_VEC[i][1]));
            chk_eq("R9 rst", int'(rec_rst_n), int'(HANG_VEC[i][0]));
            @(negedge clk);
        end

        chk_eq("R8 ovf sticky", int'(ovf_flag), 1);
        read("R7 request in idle", 1'b0, 0);

        // R10 rewake sees only pre-roll
        for (int i = 0; i < 3; i++) push();
        frame(1'b1);
        chk_eq("R8 ovf cleared on wake", int'(ovf_flag), 0);
        settle("R4 rewake");
        for (int k = 0; k < PRE; k++) read("R10 preroll after sleep", 1'b1, nxt - PRE + k);
        read("R10 old unread discarded", 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule